// File: doc/BRIEF.md
# Charge Status and Charge-Switch Output Generator

This block turns the phase code of a battery charge sequencer and a handful of analog comparator flags into three pin-level outputs. The first is a status LED drive that blinks a pattern set by the phase. The second is a temperature-window LED drive. The third is the charge-switch control.

Every blink pattern and the top-off duty window is timed from an external 1 ms tick. When the phase code changes, each pattern starts again from its first millisecond. This means a new phase never shows a partial first period.

The charge switch has two modes. With the `ext_reg` strap low, the switch is hysteretic: the sense-low flag turns it on, the sense-high flag turns it off, and between the two it keeps its state. With the strap high, it simply follows the charge enable so that an external regulator can be gated. In top-off phase the charge enable is limited to a short window at the start of each long cycle.

Top module: `chg_status_out`

## Requirements
- R1: In pending phase (code 0) the status output is high for the first LONG_MS ticks and low for the next SHORT_MS ticks of each repeating period (defaults 1375 and 125).
- R2: In discharge phase (code 1) the status output is low for the first LONG_MS ticks and high for the next SHORT_MS ticks of each repeating period.
- R3: The status output is low in fast phase (code 2). It is high in complete (4), absent (5) and the unused codes 6 and 7.
- R4: In top-off phase (code 3) the status output is low for SHORT_MS ticks, then high for SHORT_MS ticks, repeating.
- R5: While `ovr_volt` is high, both `stat_led` and `temp_led` are high in the same cycle, whatever the phase.
- R6: With `ovr_volt` low, `temp_led` equals `temp_ok` in the same cycle.
- R7: Charge is enabled in fast phase. In top-off phase it is enabled only during the first TOP_ON_MS ticks of each period of TOP_ON_MS+TOP_OFF_MS ticks (defaults 4000 and 30000). In all other phases it is disabled and `chg_sw` is low.
- R8: With `ext_reg` low, an internal switch latch updates on each clock edge. It clears when charge is disabled or `sns_hi` is high. Otherwise it sets when `sns_lo` is high, and otherwise it holds. `chg_sw` is the latch ANDed with the charge enable.
- R9: With `ext_reg` high, `chg_sw` equals the charge enable in the same cycle, regardless of the sense flags.
- R10: In the cycle where `phase` differs from its value at the previous clock edge, both pattern timers read zero. A tick in that cycle is not counted. Each timer then counts one per tick and wraps at the end of its period.
- R11: During and right after reset, both timers and the switch latch are zero. With phase 0 this gives `stat_led` high and `chg_sw` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| phase | input | 3 | Charge phase code (0 pend, 1 discharge, 2 fast, 3 top-off, 4 complete, 5 absent) |
| ovr_volt | input | 1 | Cell voltage above maximum |
| temp_ok | input | 1 | Temperature inside the allowed window |
| sns_lo | input | 1 | Sense voltage below the low threshold |
| sns_hi | input | 1 | Sense voltage above the high threshold |
| ext_reg | input | 1 | External regulation select |
| stat_led | output | 1 | Charge status LED drive |
| temp_led | output | 1 | Temperature status LED drive |
| chg_sw | output | 1 | Charge-switch control |

## Verification
A bad blink timer shows up at `stat_led` as an edge that is too early or too late. It is detected within one pattern period after a phase change, or at the first wrap. A wrong top-off window counter moves the `chg_sw` on/off boundary, and a stuck switch latch shows up at `chg_sw` one clock after the sense flags change. The override and temperature paths are combinational and are compared in every cycle against a behavioural model.

// File: rtl/chg_out_pkg.sv
package chg_out_pkg;
   localparam int PH_W = 3;
   localparam logic [PH_W-1:0] PH_PEND   = 3'd0;
   localparam logic [PH_W-1:0] PH_DISCH  = 3'd1;
   localparam logic [PH_W-1:0] PH_FAST   = 3'd2;
   localparam logic [PH_W-1:0] PH_TOPOFF = 3'd3;
   localparam logic [PH_W-1:0] PH_DONE   = 3'd4;
   localparam logic [PH_W-1:0] PH_ABSENT = 3'd5;
endpackage

// File: rtl/chg_phase_timer.sv
module chg_phase_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         tick,
   input  logic [W-1:0] wrap,
   output logic [W-1:0] count_eff
);
   localparam logic [W-1:0] ONE = 1;
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (restart)          cnt <= '0;
      else if (tick) begin
         if (cnt >= wrap - ONE)  cnt <= '0;
         else                    cnt <= cnt + ONE;
      end
   end

   assign count_eff = restart ? '0 : cnt;

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0)); // R10
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> (cnt < wrap)); // R10
endmodule

// File: rtl/chg_led_pattern.sv
module chg_led_pattern
   import chg_out_pkg::*;
#(
   parameter int W        = 16,
   parameter int LONG_MS  = 1375,
   parameter int SHORT_MS = 125
) (
   input  logic [PH_W-1:0] phase,
   input  logic [W-1:0]    bcnt,
   input  logic            ovr_volt,
   input  logic            temp_ok,
   output logic            stat_led,
   output logic            temp_led
);
   localparam logic [W-1:0] LONG_C  = W'(LONG_MS);
   localparam logic [W-1:0] SHORT_C = W'(SHORT_MS);
   logic pat;

   always_comb begin
      case (phase)
         PH_PEND:   pat = (bcnt < LONG_C);
         PH_DISCH:  pat = (bcnt >= LONG_C);
         PH_FAST:   pat = 1'b0;
         PH_TOPOFF: pat = (bcnt >= SHORT_C);
         default:   pat = 1'b1;
      endcase
   end

   assign stat_led = pat | ovr_volt;
   assign temp_led = temp_ok | ovr_volt;
endmodule

// File: rtl/chg_sw_drive.sv
module chg_sw_drive (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_en,
   input  logic ext_reg,
   input  logic sns_lo,
   input  logic sns_hi,
   output logic chg_sw
);
   logic sw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  sw_q <= 1'b0;
      else if (!gate_en || sns_hi) sw_q <= 1'b0;
      else if (sns_lo)             sw_q <= 1'b1;
   end

   assign chg_sw = ext_reg ? gate_en : (gate_en & sw_q);

   AST_SW_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && sns_hi) |=> !sw_q); // R8
   AST_SW_LO_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && sns_lo && !sns_hi) |=> sw_q); // R8
   AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && !sns_lo && !sns_hi) |=> (sw_q == $past(sw_q))); // R8
endmodule

// File: rtl/chg_status_out.sv
module chg_status_out
   import chg_out_pkg::*;
#(
   parameter int LONG_MS    = 1375,
   parameter int SHORT_MS   = 125,
   parameter int TOP_ON_MS  = 4000,
   parameter int TOP_OFF_MS = 30000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_ms,
   input  logic [2:0] phase,
   input  logic       ovr_volt,
   input  logic       temp_ok,
   input  logic       sns_lo,
   input  logic       sns_hi,
   input  logic       ext_reg,
   output logic       stat_led,
   output logic       temp_led,
   output logic       chg_sw
);
   localparam int BL_PER = LONG_MS + SHORT_MS;
   localparam int TO_PER = TOP_ON_MS + TOP_OFF_MS;
   localparam int MAXPER = (BL_PER > TO_PER) ? BL_PER : TO_PER;
   localparam int CNT_W  = $clog2(MAXPER + 1);

   generate
      if (SHORT_MS < 1 || LONG_MS <= SHORT_MS) begin : g_bad_blink
         $error("blink timing: need LONG_MS > SHORT_MS >= 1");
      end
      if (TOP_ON_MS < 1 || TOP_OFF_MS < 1) begin : g_bad_top
         $error("top-off window: both halves must be at least 1 ms");
      end
   endgenerate

   logic [PH_W-1:0]  phase_q;
   logic             restart;
   logic [CNT_W-1:0] blink_wrap, bcnt, tcnt;
   logic             gate_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_PEND;
      else        phase_q <= phase;
   end

   assign restart    = (phase != phase_q);
   assign blink_wrap = (phase == PH_TOPOFF) ? CNT_W'(2 * SHORT_MS) : CNT_W'(BL_PER);

   chg_phase_timer #(.W(CNT_W)) u_blink (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick_ms),
      .wrap(blink_wrap), .count_eff(bcnt));

   chg_phase_timer #(.W(CNT_W)) u_topwin (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick_ms),
      .wrap(CNT_W'(TO_PER)), .count_eff(tcnt));

   assign gate_en = (phase == PH_FAST) ||
                    ((phase == PH_TOPOFF) && (tcnt < CNT_W'(TOP_ON_MS)));

   chg_led_pattern #(.W(CNT_W), .LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS)) u_leds (
      .phase(phase), .bcnt(bcnt), .ovr_volt(ovr_volt), .temp_ok(temp_ok),
      .stat_led(stat_led), .temp_led(temp_led));

   chg_sw_drive u_sw (
      .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .ext_reg(ext_reg),
      .sns_lo(sns_lo), .sns_hi(sns_hi), .chg_sw(chg_sw));

   AST_OVR_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_volt |-> (stat_led && temp_led)); // R5
   AST_FAST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_FAST) && !ovr_volt) |-> !stat_led); // R3
   AST_SW_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase != PH_FAST) && (phase != PH_TOPOFF)) |-> !chg_sw); // R7
   AST_EXT_FAST_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_reg && (phase == PH_FAST)) |-> chg_sw); // R9
endmodule

// File: tb/sim_chg_status_out.sv
module sim_chg_status_out;
   localparam int LONG  = 13;
   localparam int SHORT = 3;
   localparam int TON   = 20;
   localparam int TOFF  = 70;

   logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0;
   logic [2:0] phase = 3'd0;
   logic ovr_volt = 0, temp_ok = 0, sns_lo = 0, sns_hi = 0, ext_reg = 0;
   logic stat_led, temp_led, chg_sw;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   chg_status_out #(.LONG_MS(LONG), .SHORT_MS(SHORT), .TOP_ON_MS(TON), .TOP_OFF_MS(TOFF)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .phase(phase), .ovr_volt(ovr_volt),
      .temp_ok(temp_ok), .sns_lo(sns_lo), .sns_hi(sns_hi), .ext_reg(ext_reg),
      .stat_led(stat_led), .temp_led(temp_led), .chg_sw(chg_sw));

   // behavioural reference state
   int m_b = 0, m_t = 0, m_prev = 0;
   bit m_sw = 0;

   function automatic int eff_b();
      return (int'(phase) != m_prev) ? 0 : m_b;
   endfunction
   function automatic int eff_t();
      return (int'(phase) != m_prev) ? 0 : m_t;
   endfunction
   function automatic bit gate_m();
      return (phase == 3'd2) || (phase == 3'd3 && eff_t() < TON);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_b = 0; m_t = 0; m_prev = 0; m_sw = 0;
      end else begin
         bit g;
         int bw;
         g  = gate_m();
         bw = (phase == 3'd3) ? 2 * SHORT : LONG + SHORT;
         if (!g || sns_hi) m_sw = 0;
         else if (sns_lo)  m_sw = 1;
         if (int'(phase) != m_prev) begin
            m_b = 0; m_t = 0;
         end else if (tick_ms) begin
            m_b = (m_b >= bw - 1) ? 0 : m_b + 1;
            m_t = (m_t >= TON + TOFF - 1) ? 0 : m_t + 1;
         end
         m_prev = int'(phase);
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %b expected %b (phase %0d)", req, $time, act, exp, phase);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         bit es, et, ec, g;
         int b;
         string rs, rc;
         b = eff_b();
         g = gate_m();
         case (phase)
            3'd0: begin es = (b < LONG);   rs = "R1"; end
            3'd1: begin es = (b >= LONG);  rs = "R2"; end
            3'd2: begin es = 0;            rs = "R3"; end
            3'd3: begin es = (b >= SHORT); rs = "R4"; end
            default: begin es = 1;         rs = "R3"; end
         endcase
         if (int'(phase) != m_prev) rs = "R10";
         if (!rst_n) rs = "R11";
         es = es | ovr_volt;
         if (ovr_volt) rs = "R5";
         et = temp_ok | ovr_volt;
         ec = ext_reg ? g : (g & m_sw);
         rc = ext_reg ? "R9" : (phase == 3'd3 ? "R7" : "R8");
         check(rs, stat_led, es);
         check(ovr_volt ? "R5" : "R6", temp_led, et);
         check(rc, chg_sw, ec);
      end
   end

   // 1 ms tick every other clock
   initial begin
      forever begin
         @(posedge clk); #2 tick_ms = ~tick_ms;
         @(posedge clk); #2 tick_ms = 1'b0;
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #3_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      cyc(4);
      @(negedge clk);
      check("R11", stat_led, 1'b1);
      check("R11", chg_sw, 1'b0);
      @(posedge clk); #2 rst_n = 1;
      // R1 pending blink, temperature window toggles
      temp_ok = 1; cyc(40); temp_ok = 0; cyc(30);
      // R2 discharge, then mid-pattern return to pending (R10)
      phase = 3'd1; cyc(37);
      phase = 3'd0; @(negedge clk); check("R10", stat_led, 1'b1);
      @(posedge clk); #2 phase = 3'd1; cyc(20);
      // R8 fast, hysteretic switching
      phase = 3'd2; temp_ok = 1; cyc(3);
      sns_lo = 1; cyc(2); sns_lo = 0; cyc(4);
      sns_hi = 1; cyc(2); sns_hi = 0; cyc(3);
      sns_lo = 1; sns_hi = 1; cyc(2); sns_hi = 0; cyc(2); sns_lo = 0; cyc(3);
      // R5 override
      ovr_volt = 1; temp_ok = 0; cyc(3); ovr_volt = 0; cyc(2);
      // R7/R4 top-off, switch demand held
      sns_lo = 1; phase = 3'd3; cyc(400);
      sns_lo = 0; sns_hi = 1; cyc(10); sns_hi = 0; sns_lo = 1;
      // R9 external regulation in top-off and fast
      ext_reg = 1; sns_lo = 0; cyc(200);
      phase = 3'd2; sns_hi = 1; cyc(6); sns_hi = 0; ext_reg = 0; cyc(4);
      // R3 complete, absent, unused codes
      phase = 3'd4; cyc(10); ovr_volt = 1; cyc(2); ovr_volt = 0;
      phase = 3'd5; cyc(10); phase = 3'd7; cyc(6); phase = 3'd6; cyc(6);
      // quick phase flips
      for (int k = 0; k < 6; k++) begin phase = 3'(k % 4); cyc(1 + k); end
      phase = 3'd3; cyc(60);
      ext_reg = 1; phase = 3'd0; cyc(10);
      finish_run();
   end
endmodule